// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block keeps a rolling record of 32-bit trace words in a 2048-slot on-chip RAM. A producer presents one word per cycle with a valid strobe and an optional trigger flag. While capture is enabled, each valid word goes into the slot the address register points at, and the pointer then moves on by one slot. After slot 2047 it returns to slot 0 and sets a sticky overflow flag. Once that flag is set, the whole RAM holds valid words. While the flag is clear, the valid words are the slots below the current address divided by four.

Software reaches the block through a five-register window on a simple request bus. Read data comes back one cycle after the request. The address register is kept as a byte address. Accesses to the data register can advance it automatically, with separate enables for reads and for writes. Software uses this to pre-fill marker words before a run and to drain the RAM afterwards. A post-trigger counter can end a run: in that mode, once a trigger is seen, a fixed number of further words is stored and capture then turns itself off. The count is always a multiple of 16. A count of zero means the trigger is ignored and capture keeps overwriting the oldest data.

Top module: `trace_buf`

## Requirements
- R1: After reset, reading any register returns zero and `rvalid_o` is low.
- R2: The word offsets on `addr_i` are 0 control, 1 status, 2 trigger count, 3 address and 4 data. A read request returns `rvalid_o` high with its data in the following cycle. Offsets 5 to 7 read as zero.
- R3: While control bit 0 is set, each word with `trace_valid_i` high is stored at slot address>>2 and the address advances by 4. While bit 0 is clear, trace words are dropped and the address does not move.
- R4: A capture write to slot 2047 moves the address to 0 and sets status bit 21. The bit stays set until software writes status with bit 21 at 0. Writing status with bit 21 at 1 leaves the bit unchanged.
- R5: The address register reads back as a byte address. Bits 1:0 and bits above 12 read as zero. A write loads slot wdata[12:2].
- R6: A data-register write stores the word at the current slot. The address then advances by 4 only if control bit 2 is set.
- R7: A data-register read returns the word at the current slot. The address then advances by 4 only if control bit 3 is set.
- R8: The trigger count register reads back with bits 3:0 forced to zero.
- R9: With control bits 1 and 0 set and a nonzero count N, the word present in the cycle the trigger is seen is stored. Exactly N further words are then stored, after which control bit 0 reads 0 and no more words are accepted.
- R10: With control bit 1 clear, or with a count of zero, the trigger input has no effect and capture keeps running.
- R11: While control bit 0 is set, data-register reads return zero, and data-register writes and address-register writes are ignored. None of these moves the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| trace_valid_i | input | 1 | Trace word present |
| trace_data_i | input | 32 | Trace word |
| trace_trig_i | input | 1 | Trigger marker for the current cycle |

## Verification
The bound checker checks on every cycle that the pointer steps by exactly one slot with wrap on each capture write, and that the overflow flag rises only on a write to the last slot. It also checks that the flag clears only through a status write, that software cannot move the pointer while capture runs, and that capture turns itself off only in trigger-counter mode. The bench scenarios are needed for the rest: which word lands in which slot, the exact count of words stored after a trigger, the rounding of the count, and the auto-increment choices seen through data read-back.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;
  localparam int REG_AW   = 3;
  localparam int STAT_OVF = 21;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_TCNT = 3'd2;
  localparam logic [REG_AW-1:0] RA_ADDR = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd4;

  // control bits: [3] inc on read, [2] inc on write, [1] trigger mode, [0] enable
  typedef struct packed {
    logic inc_rd;
    logic inc_wr;
    logic tmode;
    logic en;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/trace_buf_ram.sv
module trace_buf_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/trace_buf_ptr.sv
module trace_buf_ptr #(
  parameter int DEPTH = 2048,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_we_i,
  input  logic          sw_load_i,
  input  logic [IW-1:0] sw_load_val_i,
  input  logic          sw_step_i,
  input  logic          ovf_clr_i,
  output logic [IW-1:0] ptr_o,
  output logic          ovf_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] ptr_q, ptr_nxt;
  logic          ovf_q;

  assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      // capture has priority; software moves are locked out while enabled
      if (cap_we_i)       ptr_q <= ptr_nxt;
      else if (sw_load_i) ptr_q <= sw_load_val_i;
      else if (sw_step_i) ptr_q <= ptr_nxt;

      if (cap_we_i && ptr_q == LAST) ovf_q <= 1'b1;
      else if (ovf_clr_i)            ovf_q <= 1'b0;
    end
  end

  assign ptr_o = ptr_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/trace_buf_trig.sv
module trace_buf_trig #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tmode_i,
  input  logic [CW-1:0] tcnt_i,
  input  logic          trig_i,
  input  logic          cap_we_i,
  output logic          stop_o
);
  logic          armed_q;
  logic [CW-1:0] left_q;
  logic          fire;

  assign fire   = en_i && tmode_i && (tcnt_i != '0) && trig_i && !armed_q;
  assign stop_o = armed_q && cap_we_i && (left_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (!en_i || !tmode_i) begin
      armed_q <= 1'b0;
    end else if (fire) begin
      // the word in the trigger cycle is not counted
      armed_q <= 1'b1;
      left_q  <= tcnt_i;
    end else if (armed_q && cap_we_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_buf_regs.sv
module trace_buf_regs
  import trace_buf_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              stop_i,
  input  logic              ovf_i,
  input  logic [IW-1:0]     ptr_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output ctrl_t             ctrl_o,
  output logic [DW-1:0]     tcnt_o,
  output logic              data_wr_o,
  output logic              data_rd_o,
  output logic              addr_wr_o,
  output logic              ovf_clr_o,
  output logic              ctrl_wr_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] tcnt_q, snap, snap_q;
  logic          wr, rd, sw_ok, from_ram_q, rvalid_q;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign sw_ok = !ctrl_q.en;

  assign ctrl_wr_o = wr && addr_i == RA_CTRL;
  assign data_wr_o = wr && addr_i == RA_DATA && sw_ok;
  assign data_rd_o = rd && addr_i == RA_DATA && sw_ok;
  assign addr_wr_o = wr && addr_i == RA_ADDR && sw_ok;
  assign ovf_clr_o = wr && addr_i == RA_STAT && !wdata_i[STAT_OVF];

  always_comb begin
    snap = '0;
    case (addr_i)
      RA_CTRL: snap[CTRL_W-1:0] = ctrl_q;
      RA_STAT: snap[STAT_OVF]   = ovf_i;
      RA_TCNT: snap             = tcnt_q;
      RA_ADDR: snap[IW+1:0]     = {ptr_i, 2'b00};
      default: snap             = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      tcnt_q     <= '0;
      snap_q     <= '0;
      from_ram_q <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q   <= rd;
      from_ram_q <= data_rd_o;
      if (rd) snap_q <= snap;
      if (ctrl_wr_o)   ctrl_q    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (stop_i) ctrl_q.en <= 1'b0;
      if (wr && addr_i == RA_TCNT) tcnt_q <= {wdata_i[DW-1:4], 4'b0000};
    end
  end

  assign ctrl_o   = ctrl_q;
  assign tcnt_o   = tcnt_q;
  assign rdata_o  = from_ram_q ? ram_rdata_i : snap_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/trace_buf.sv
module trace_buf
  import trace_buf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  input  logic              trace_valid_i,
  input  logic [DW-1:0]     trace_data_i,
  input  logic              trace_trig_i
);
  localparam int IW = $clog2(DEPTH);

  ctrl_t         ctrl;
  logic [DW-1:0] tcnt, ram_rdata;
  logic [IW-1:0] ptr;
  logic          ovf, stop, cap_we;
  logic          data_wr, data_rd, addr_wr, ovf_clr, ctrl_wr, sw_step;

  assign cap_we  = ctrl.en && trace_valid_i;
  assign sw_step = (data_wr && ctrl.inc_wr) || (data_rd && ctrl.inc_rd);

  trace_buf_regs #(.DW(DW), .IW(IW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .stop_i(stop), .ovf_i(ovf), .ptr_i(ptr), .ram_rdata_i(ram_rdata),
    .ctrl_o(ctrl), .tcnt_o(tcnt), .data_wr_o(data_wr), .data_rd_o(data_rd),
    .addr_wr_o(addr_wr), .ovf_clr_o(ovf_clr), .ctrl_wr_o(ctrl_wr),
    .rdata_o, .rvalid_o
  );

  trace_buf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .cap_we_i(cap_we), .sw_load_i(addr_wr),
    .sw_load_val_i(wdata_i[IW+1:2]), .sw_step_i(sw_step),
    .ovf_clr_i(ovf_clr), .ptr_o(ptr), .ovf_o(ovf)
  );

  trace_buf_trig #(.CW(DW)) u_trig (
    .clk_i, .rst_ni, .en_i(ctrl.en), .tmode_i(ctrl.tmode), .tcnt_i(tcnt),
    .trig_i(trace_trig_i), .cap_we_i(cap_we), .stop_o(stop)
  );

  trace_buf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i, .we_i(cap_we || data_wr), .waddr_i(ptr),
    .wdata_i(cap_we ? trace_data_i : wdata_i),
    .re_i(data_rd), .raddr_i(ptr), .rdata_o(ram_rdata)
  );
endmodule

// File: rtl/trace_buf_chk.sv
module trace_buf_chk
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic              rvalid_o,
  input logic              cap_we,
  input logic [IW-1:0]     ptr,
  input logic              ovf,
  input logic              en,
  input logic              tmode,
  input logic              ctrl_wr
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_we && !req_i |=> $stable(ptr));

  a_r4_ovf_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> $past(cap_we && ptr == LAST));

  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !(req_i && we_i && addr_i == RA_STAT) |=> ovf);

  a_r2_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r2_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  a_r11_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !cap_we && req_i && (addr_i == RA_DATA || addr_i == RA_ADDR) |=> $stable(ptr));

  a_r9_self_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en) && !$past(ctrl_wr) |-> $past(tmode));
endmodule

bind trace_buf trace_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rvalid_o(rvalid_o), .cap_we(cap_we), .ptr(ptr), .ovf(ovf),
  .en(ctrl.en), .tmode(ctrl.tmode), .ctrl_wr(ctrl_wr)
);

// File: tb/trace_buf_test.sv
module trace_buf_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        tv = 1'b0, tt = 1'b0;
  logic [31:0] td = '0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  trace_buf uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .trace_valid_i(tv), .trace_data_i(td), .trace_trig_i(tt)
  );

  // {write, offset, req, wdata, expected}
  localparam int N = 31;
  localparam logic [71:0] VEC [N] = '{
    {1'b0, 3'd0, 4'd1, 32'h0,        32'h0},        // R1
    {1'b0, 3'd1, 4'd1, 32'h0,        32'h0},        // R1
    {1'b0, 3'd2, 4'd1, 32'h0,        32'h0},        // R1
    {1'b0, 3'd3, 4'd1, 32'h0,        32'h0},        // R1
    {1'b1, 3'd0, 4'd2, 32'hC,        32'h0},
    {1'b0, 3'd0, 4'd2, 32'h0,        32'hC},        // R2
    {1'b1, 3'd2, 4'd8, 32'h1F,       32'h0},
    {1'b0, 3'd2, 4'd8, 32'h0,        32'h10},       // R8
    {1'b1, 3'd2, 4'd8, 32'hFFFFFFFF, 32'h0},
    {1'b0, 3'd2, 4'd8, 32'h0,        32'hFFFFFFF0}, // R8
    {1'b1, 3'd3, 4'd5, 32'h123,      32'h0},
    {1'b0, 3'd3, 4'd5, 32'h0,        32'h120},      // R5
    {1'b1, 3'd3, 4'd5, 32'hFFFFFFFF, 32'h0},
    {1'b0, 3'd3, 4'd5, 32'h0,        32'h1FFC},     // R5
    {1'b0, 3'd5, 4'd2, 32'h0,        32'h0},        // R2
    {1'b0, 3'd7, 4'd2, 32'h0,        32'h0},        // R2
    {1'b1, 3'd0, 4'd6, 32'h4,        32'h0},
    {1'b1, 3'd3, 4'd6, 32'h40,       32'h0},
    {1'b1, 3'd4, 4'd6, 32'hAAAA5555, 32'h0},
    {1'b1, 3'd4, 4'd6, 32'h12345678, 32'h0},
    {1'b0, 3'd3, 4'd6, 32'h0,        32'h48},       // R6
    {1'b1, 3'd0, 4'd7, 32'h8,        32'h0},
    {1'b1, 3'd3, 4'd7, 32'h40,       32'h0},
    {1'b0, 3'd4, 4'd7, 32'h0,        32'hAAAA5555}, // R7
    {1'b0, 3'd4, 4'd7, 32'h0,        32'h12345678}, // R7
    {1'b0, 3'd3, 4'd7, 32'h0,        32'h48},       // R7
    {1'b1, 3'd0, 4'd7, 32'h0,        32'h0},
    {1'b1, 3'd3, 4'd7, 32'h40,       32'h0},
    {1'b0, 3'd4, 4'd7, 32'h0,        32'hAAAA5555}, // R7 no increment
    {1'b0, 3'd3, 4'd7, 32'h0,        32'h40},       // R7
    {1'b1, 3'd2, 4'd9, 32'h0,        32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata; v = rvalid;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_rd(a, d, v);
    check(tag, d, exp);
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk); tv = 1'b1; td = d; tt = t;
    @(negedge clk); tv = 1'b0; tt = 1'b0;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 rvalid after reset", {31'b0, rvalid}, 32'h0);

    for (int i = 0; i < N; i++) begin
      if (VEC[i][71]) bus_wr(VEC[i][70:68], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][70:68], d, v);
        check($sformatf("R%0d table row %0d", VEC[i][67:64], i), d, VEC[i][31:0]);
      end
    end
    bus_rd(3'd0, d, v);
    check("R2 rvalid on read", {31'b0, v}, 32'h1);

    // R3 capture / drop, R11 lockout
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd3, 32'h1C);
    bus_wr(3'd4, 32'h77777777);
    bus_wr(3'd3, 32'h10);
    push(32'hDEAD0001, 1'b0);
    rd_chk("R3 dropped word keeps address", 3'd3, 32'h10);
    bus_wr(3'd0, 32'h1);
    push(32'hA1, 1'b0); push(32'hA2, 1'b0); push(32'hA3, 1'b0);
    rd_chk("R3 address after capture", 3'd3, 32'h1C);
    rd_chk("R11 data read locked", 3'd4, 32'h0);
    bus_wr(3'd4, 32'h0BAD0BAD);
    bus_wr(3'd3, 32'h0);
    rd_chk("R11 address locked", 3'd3, 32'h1C);
    bus_wr(3'd0, 32'h8);
    bus_wr(3'd3, 32'h10);
    rd_chk("R3 slot 4", 3'd4, 32'hA1);
    rd_chk("R3 slot 5", 3'd4, 32'hA2);
    rd_chk("R3 slot 6", 3'd4, 32'hA3);
    rd_chk("R11 locked write dropped", 3'd4, 32'h77777777);

    // R4 wrap and overflow
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd3, 32'h1FF8);
    bus_wr(3'd0, 32'h1);
    push(32'hB1, 1'b0);
    rd_chk("R4 no overflow before wrap", 3'd1, 32'h0);
    push(32'hB2, 1'b0);
    rd_chk("R4 overflow set on wrap", 3'd1, 32'h00200000);
    rd_chk("R4 address wrapped", 3'd3, 32'h0);
    push(32'hB3, 1'b0);
    rd_chk("R4 address after wrap", 3'd3, 32'h4);
    bus_wr(3'd0, 32'h8);
    bus_wr(3'd1, 32'h00200000);
    rd_chk("R4 write one keeps flag", 3'd1, 32'h00200000);
    bus_wr(3'd1, 32'h0);
    rd_chk("R4 write zero clears", 3'd1, 32'h0);
    bus_wr(3'd3, 32'h1FFC);
    rd_chk("R4 slot 2047", 3'd4, 32'hB2);
    rd_chk("R4 slot 0", 3'd4, 32'hB3);

    // R9 post-trigger stop, count 16
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd2, 32'h1F);
    bus_wr(3'd3, 32'h0);
    bus_wr(3'd0, 32'h3);
    for (int k = 0; k < 21; k++) push(32'hC0000000 + k, k == 5);
    rd_chk("R9 still enabled before last", 3'd0, 32'h3);
    rd_chk("R9 address before last", 3'd3, 32'h54);
    push(32'hC0000015, 1'b0);
    rd_chk("R9 stopped after count", 3'd0, 32'h2);
    rd_chk("R9 address at stop", 3'd3, 32'h58);
    push(32'hC0000016, 1'b0);
    rd_chk("R9 no capture after stop", 3'd3, 32'h58);
    bus_wr(3'd0, 32'h8);
    bus_wr(3'd3, 32'h14);
    rd_chk("R9 trigger word stored", 3'd4, 32'hC0000005);

    // R10 trigger ignored: count zero, then mode off
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd2, 32'h0);
    bus_wr(3'd3, 32'h0);
    bus_wr(3'd0, 32'h3);
    push(32'h1, 1'b1);
    for (int k = 0; k < 20; k++) push(32'h2, 1'b0);
    rd_chk("R10 zero count keeps running", 3'd0, 32'h3);
    rd_chk("R10 zero count address", 3'd3, 32'h54);
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd2, 32'h10);
    bus_wr(3'd3, 32'h0);
    bus_wr(3'd0, 32'h1);
    push(32'h1, 1'b1);
    for (int k = 0; k < 20; k++) push(32'h2, 1'b0);
    rd_chk("R10 mode off keeps running", 3'd0, 32'h1);
    rd_chk("R10 mode off address", 3'd3, 32'h54);

    finish_run();
  end
endmodule